// File: doc/BRIEF.md
# RGMII to GMII Interface Adapter

This block sits between an Ethernet MAC that moves one byte per clock and a PHY that exchanges four-bit nibbles on both edges of a clock. On the transmit side it takes a byte, an enable and an error flag on a 125 MHz reference clock. It drives a forwarded clock, a four-bit data bus and a single control line toward the PHY. At gigabit speed the low nibble is presented while the forwarded clock is high and the high nibble while it is low. At 10 and 100 Mb/s the forwarded clock is divided down from the reference. Each nibble then fills a whole forwarded-clock period, and the MAC is told through a one-cycle take pulse when its byte has been accepted.

On the receive side the block captures data and control on both edges of the clock recovered by the PHY and rebuilds a byte with valid and error flags. The control line carries the enable or valid flag on the rising edge. On the falling edge it carries that flag XORed with the error flag, so the error is recovered by XORing the two edge samples. The link speed is a static input. The receive outputs stay in the receive clock domain.

Top module: `rgmii_bridge`

## Requirements
- R1: With the gigabit speed selected, the forwarded clock follows the reference clock. The pad data shows byte bits [3:0] while the forwarded clock is high and bits [7:4] while it is low. The byte shown is the one sampled at the reference rising edge that starts that high half.
- R2: At gigabit speed, the transmit control pad shows the enable during the high half and enable XOR error during the low half.
- R3: At gigabit speed, the take output is high in every cycle out of reset, so a new byte is accepted on every reference edge.
- R4: At 100 Mb/s (speed code 01) the forwarded clock period is 5 reference cycles, high for the first 2. At 10 Mb/s (speed code 00) it is 50 reference cycles, high for the first 25.
- R5: At 10/100, take is high for one reference cycle every two forwarded-clock periods, and the byte is accepted at the reference edge that ends that cycle. Bits [3:0] are held on the pad for the first forwarded period and bits [7:4] for the second, with the same value in both reference-clock halves. The pad data changes only where the forwarded clock rises.
- R6: At 10/100, the control pad shows the enable for the high part of each forwarded period and enable XOR error for the low part.
- R7: At gigabit speed, the receive byte is the falling-edge nibble above the rising-edge nibble. Valid is the rising-edge control sample and error is the XOR of the two control samples. The result appears after the next receive rising edge.
- R8: At 10/100, while the rising-edge control sample is high, consecutive rising-edge nibbles pair up, low nibble first, starting at the first valid nibble. Falling-edge data is ignored. After the second nibble of a pair, valid is high for one cycle with the assembled byte and the OR of both nibbles' errors. After the first nibble, valid, error and data are all zero.
- R9: At 10/100, a nibble whose rising control sample is low gives valid 0, data 0 and error equal to the XOR of its two control samples, and it restarts the nibble pairing.
- R10: While either reset is held, the outputs of that domain are low: forwarded clock, pad data, transmit control and take, or the receive byte, valid and error.
- R11: Speed code 11 behaves as gigabit speed (code 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_ref_clk_i | input | 1 | 125 MHz transmit reference clock |
| tx_arst_ni | input | 1 | Asynchronous active-low transmit reset |
| link_speed_i | input | 2 | Static speed: 00 10 Mb/s, 01 100 Mb/s, 1x gigabit |
| mac_txd_i | input | 8 | Transmit byte from the MAC |
| mac_txen_i | input | 1 | Transmit enable from the MAC |
| mac_txer_i | input | 1 | Transmit error from the MAC |
| mac_tx_take_o | output | 1 | Byte presented this cycle is accepted at the next reference edge |
| phy_txc_o | output | 1 | Forwarded transmit clock |
| phy_txd_o | output | 4 | Transmit nibble pads |
| phy_txctl_o | output | 1 | Transmit control pad (enable / encoded error) |
| phy_rxc_i | input | 1 | Receive clock recovered by the PHY |
| rx_arst_ni | input | 1 | Asynchronous active-low receive reset |
| phy_rxd_i | input | 4 | Receive nibble pads |
| phy_rxctl_i | input | 1 | Receive control pad (valid / encoded error) |
| mac_rxd_o | output | 8 | Rebuilt receive byte |
| mac_rxdv_o | output | 1 | Receive byte valid |
| mac_rxer_o | output | 1 | Receive error |

## Verification
The bench checks which nibble sits in which half of the forwarded clock, and the XOR encoding on the falling half. A design that swapped the nibbles or sent the raw error flag would put the wrong value on the pads in the low half. At 10 and 100 Mb/s it counts the exact divider period, the high time and the spacing of the take pulse. An off-by-one divider or a take pulse issued in the wrong cycle would shift every later byte. On receive it drives junk on the falling-edge data at the slow speeds and ends bursts with an odd number of valid nibbles. Pairing that does not restart when valid drops would then assemble bytes from the wrong nibbles. It also sends error-only nibbles and uses speed code 11 to show that it acts as gigabit.

// File: rtl/rgmii_bridge_pkg.sv
package rgmii_bridge_pkg;

  typedef enum logic [1:0] {
    LINK_10    = 2'b00,
    LINK_100   = 2'b01,
    LINK_1G    = 2'b10,
    LINK_1G_B  = 2'b11
  } link_speed_e;

  localparam int unsigned DIV_100_DEF = 5;
  localparam int unsigned DIV_10_DEF  = 50;

  function automatic logic speed_is_gig(input logic [1:0] spd);
    return spd[1];
  endfunction

endpackage

// File: rtl/rgmii_rst_sync.sv
module rgmii_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/rgmii_ddr_out.sv
module rgmii_ddr_out #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] fall_i,
  output logic [WIDTH-1:0] pad_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    logic rise_q;
    logic fall_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else if (ce_i) begin
        rise_q <= rise_i[b];
        fall_q <= fall_i[b];
      end
    end

    assign pad_o[b] = clk_i ? rise_q : fall_q;
  end

endmodule

// File: rtl/rgmii_tx_path.sv
module rgmii_tx_path
  import rgmii_bridge_pkg::*;
#(
  parameter int unsigned DIV_100 = DIV_100_DEF,
  parameter int unsigned DIV_10  = DIV_10_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] speed_i,
  input  logic [7:0] txd_i,
  input  logic       txen_i,
  input  logic       txer_i,
  output logic       take_o,
  output logic       txc_o,
  output logic [3:0] txd_o,
  output logic       txctl_o
);

  localparam int unsigned CNT_W = $clog2(DIV_10 + 1);
  localparam logic [CNT_W-1:0] DIV_100_C = CNT_W'(DIV_100);
  localparam logic [CNT_W-1:0] DIV_10_C  = CNT_W'(DIV_10);

  logic             gig;
  logic [CNT_W-1:0] div_sel;
  logic [CNT_W-1:0] half_sel;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             wrap;

  logic [3:0]       hi_q;
  logic             en_q, er_q;
  logic             hold_ce;

  logic             slot_start, slot_mid, slot_fall;

  logic             clk_ce, dat_ce, ctl_ce;
  logic             clk_r, clk_f;
  logic [3:0]       dat_r, dat_f;
  logic             ctl_r, ctl_f;

  assign gig      = speed_is_gig(speed_i);
  assign div_sel  = (speed_i == LINK_10) ? DIV_10_C : DIV_100_C;
  assign half_sel = div_sel >> 1;

  // Divider next state
  always_comb begin
    wrap    = (cnt_q >= div_sel - 1'b1);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = phase_q ^ wrap;
  end

  always_comb begin
    slot_start = (cnt_d == '0) && !phase_d;
    slot_mid   = (cnt_d == '0) &&  phase_d;
    slot_fall  = (cnt_d == half_sel);
  end

  // Pad stage next values
  always_comb begin
    hold_ce = 1'b0;
    if (gig) begin
      clk_ce = 1'b1;
      clk_r  = 1'b1;
      clk_f  = 1'b0;
      dat_ce = 1'b1;
      dat_r  = txd_i[3:0];
      dat_f  = txd_i[7:4];
      ctl_ce = 1'b1;
      ctl_r  = txen_i;
      ctl_f  = txen_i ^ txer_i;
    end else begin
      hold_ce = slot_start;
      clk_ce  = 1'b1;
      clk_r   = (cnt_d < half_sel);
      clk_f   = clk_r;
      dat_ce  = slot_start | slot_mid;
      dat_r   = slot_start ? txd_i[3:0] : hi_q;
      dat_f   = dat_r;
      ctl_ce  = slot_start | slot_mid | slot_fall;
      if (slot_start) begin
        ctl_r = txen_i;
      end else if (slot_mid) begin
        ctl_r = en_q;
      end else begin
        ctl_r = en_q ^ er_q;
      end
      ctl_f = ctl_r;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!gig) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      en_q <= 1'b0;
      er_q <= 1'b0;
    end else if (hold_ce) begin
      hi_q <= txd_i[7:4];
      en_q <= txen_i;
      er_q <= txer_i;
    end
  end

  assign take_o = gig ? rst_ni : (wrap && phase_q);

  rgmii_ddr_out #(.WIDTH(1)) u_clk_pad (
    .clk_i (clk_i), .rst_ni (rst_ni), .ce_i (clk_ce),
    .rise_i(clk_r), .fall_i (clk_f), .pad_o (txc_o)
  );

  rgmii_ddr_out #(.WIDTH(4)) u_dat_pad (
    .clk_i (clk_i), .rst_ni (rst_ni), .ce_i (dat_ce),
    .rise_i(dat_r), .fall_i (dat_f), .pad_o (txd_o)
  );

  rgmii_ddr_out #(.WIDTH(1)) u_ctl_pad (
    .clk_i (clk_i), .rst_ni (rst_ni), .ce_i (ctl_ce),
    .rise_i(ctl_r), .fall_i (ctl_f), .pad_o (txctl_o)
  );

endmodule

// File: rtl/rgmii_rx_path.sv
module rgmii_rx_path
  import rgmii_bridge_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         speed_i,
  input  logic [NIB_W-1:0]   rxd_i,
  input  logic               rxctl_i,
  output logic [2*NIB_W-1:0] rxd_o,
  output logic               rxdv_o,
  output logic               rxer_o
);

  logic [NIB_W-1:0]   rd_r_q, rd_f_q;
  logic               rc_r_q, rc_f_q;

  logic [NIB_W-1:0]   lo_q;
  logic               elo_q;
  logic               pair_q, pair_d;
  logic               lo_ce;

  logic [2*NIB_W-1:0] byte_q, byte_d;
  logic               dv_q, dv_d;
  logic               er_q, er_d;
  logic               nib_err;

  // Edge capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_r_q <= '0;
      rc_r_q <= 1'b0;
    end else begin
      rd_r_q <= rxd_i;
      rc_r_q <= rxctl_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_f_q <= '0;
      rc_f_q <= 1'b0;
    end else begin
      rd_f_q <= rxd_i;
      rc_f_q <= rxctl_i;
    end
  end

  assign nib_err = rc_r_q ^ rc_f_q;

  // Byte assembly next state
  always_comb begin
    lo_ce  = 1'b0;
    pair_d = 1'b0;
    byte_d = '0;
    dv_d   = 1'b0;
    er_d   = 1'b0;
    if (speed_is_gig(speed_i)) begin
      byte_d = {rd_f_q, rd_r_q};
      dv_d   = rc_r_q;
      er_d   = nib_err;
    end else if (!rc_r_q) begin
      er_d = nib_err;
    end else if (!pair_q) begin
      lo_ce  = 1'b1;
      pair_d = 1'b1;
    end else begin
      byte_d = {rd_r_q, lo_q};
      dv_d   = 1'b1;
      er_d   = elo_q | nib_err;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q <= 1'b0;
      byte_q <= '0;
      dv_q   <= 1'b0;
      er_q   <= 1'b0;
    end else begin
      pair_q <= pair_d;
      byte_q <= byte_d;
      dv_q   <= dv_d;
      er_q   <= er_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      elo_q <= 1'b0;
    end else if (lo_ce) begin
      lo_q  <= rd_r_q;
      elo_q <= nib_err;
    end
  end

  assign rxd_o  = byte_q;
  assign rxdv_o = dv_q;
  assign rxer_o = er_q;

endmodule

// File: rtl/rgmii_bridge.sv
module rgmii_bridge
  import rgmii_bridge_pkg::*;
#(
  parameter int unsigned DIV_100    = DIV_100_DEF,
  parameter int unsigned DIV_10     = DIV_10_DEF,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       tx_ref_clk_i,
  input  logic       tx_arst_ni,
  input  logic [1:0] link_speed_i,
  input  logic [7:0] mac_txd_i,
  input  logic       mac_txen_i,
  input  logic       mac_txer_i,
  output logic       mac_tx_take_o,
  output logic       phy_txc_o,
  output logic [3:0] phy_txd_o,
  output logic       phy_txctl_o,
  input  logic       phy_rxc_i,
  input  logic       rx_arst_ni,
  input  logic [3:0] phy_rxd_i,
  input  logic       phy_rxctl_i,
  output logic [7:0] mac_rxd_o,
  output logic       mac_rxdv_o,
  output logic       mac_rxer_o
);

  logic tx_rst_sync_n;
  logic rx_rst_sync_n;

  rgmii_rst_sync #(.STAGES(RST_STAGES)) u_tx_rst (
    .clk_i (tx_ref_clk_i), .arst_ni (tx_arst_ni), .rst_no (tx_rst_sync_n)
  );

  rgmii_rst_sync #(.STAGES(RST_STAGES)) u_rx_rst (
    .clk_i (phy_rxc_i), .arst_ni (rx_arst_ni), .rst_no (rx_rst_sync_n)
  );

  rgmii_tx_path #(.DIV_100(DIV_100), .DIV_10(DIV_10)) u_tx (
    .clk_i   (tx_ref_clk_i),
    .rst_ni  (tx_rst_sync_n),
    .speed_i (link_speed_i),
    .txd_i   (mac_txd_i),
    .txen_i  (mac_txen_i),
    .txer_i  (mac_txer_i),
    .take_o  (mac_tx_take_o),
    .txc_o   (phy_txc_o),
    .txd_o   (phy_txd_o),
    .txctl_o (phy_txctl_o)
  );

  rgmii_rx_path #(.NIB_W(4)) u_rx (
    .clk_i   (phy_rxc_i),
    .rst_ni  (rx_rst_sync_n),
    .speed_i (link_speed_i),
    .rxd_i   (phy_rxd_i),
    .rxctl_i (phy_rxctl_i),
    .rxd_o   (mac_rxd_o),
    .rxdv_o  (mac_rxdv_o),
    .rxer_o  (mac_rxer_o)
  );

endmodule

// File: rtl/rgmii_bridge_checker.sv
module rgmii_bridge_checker (
  input logic       tx_clk,
  input logic       tx_arst_n,
  input logic       tx_run,
  input logic       rx_clk,
  input logic       rx_arst_n,
  input logic       rx_run,
  input logic [1:0] speed,
  input logic       take,
  input logic       txc,
  input logic [3:0] txd,
  input logic       txctl,
  input logic [7:0] rxd,
  input logic       rxdv,
  input logic       rxer
);

  assert_take_every_cycle_R3: assert property (
    @(posedge tx_clk) disable iff (!tx_arst_n)
      (speed[1] && tx_run) |-> take
  );

  assert_take_single_R5: assert property (
    @(posedge tx_clk) disable iff (!tx_arst_n)
      (!speed[1] && tx_run && take) |=> !take
  );

  assert_txd_moves_on_rise_R5: assert property (
    @(negedge tx_clk) disable iff (!tx_arst_n)
      (!speed[1] && tx_run && $past(tx_run) && !$rose(txc)) |-> $stable(txd)
  );

  assert_rx_valid_single_R8: assert property (
    @(posedge rx_clk) disable iff (!rx_arst_n)
      (!speed[1] && rx_run && rxdv) |=> !rxdv
  );

  always @(negedge tx_clk) begin
    if (!tx_arst_n) begin
      assert_tx_idle_in_reset_R10: assert (txc == 1'b0 && txd == 4'h0 &&
                                           txctl == 1'b0 && take == 1'b0);
    end
  end

  always @(negedge rx_clk) begin
    if (!rx_arst_n) begin
      assert_rx_idle_in_reset_R10: assert (rxd == 8'h00 && !rxdv && !rxer);
    end
  end

endmodule

bind rgmii_bridge rgmii_bridge_checker u_chk (
  .tx_clk    (tx_ref_clk_i),
  .tx_arst_n (tx_arst_ni),
  .tx_run    (tx_rst_sync_n),
  .rx_clk    (phy_rxc_i),
  .rx_arst_n (rx_arst_ni),
  .rx_run    (rx_rst_sync_n),
  .speed     (link_speed_i),
  .take      (mac_tx_take_o),
  .txc       (phy_txc_o),
  .txd       (phy_txd_o),
  .txctl     (phy_txctl_o),
  .rxd       (mac_rxd_o),
  .rxdv      (mac_rxdv_o),
  .rxer      (mac_rxer_o)
);

// File: tb/rgmii_bridge_tb_top.sv
`timescale 1ns/1ps
module rgmii_bridge_tb_top;

  logic       tx_clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       tx_rst_n, rx_rst_n;
  logic [1:0] speed;
  logic [7:0] m_txd;
  logic       m_txen, m_txer;
  logic       take, txc, txctl;
  logic [3:0] txd;
  logic [3:0] rxd;
  logic       rxctl;
  logic [7:0] o_rxd;
  logic       o_rxdv, o_rxer;

  int errs   = 0;
  int checks = 0;
  int rx_half = 4;

  logic [7:0] exp_d;
  logic       exp_dv, exp_er;
  bit         mdl_pair;
  logic [3:0] mdl_lo;
  logic       mdl_elo;

  always #4 tx_clk = ~tx_clk;
  always #(rx_half) rx_clk = ~rx_clk;

  rgmii_bridge dut_i (
    .tx_ref_clk_i (tx_clk),  .tx_arst_ni (tx_rst_n), .link_speed_i (speed),
    .mac_txd_i    (m_txd),   .mac_txen_i (m_txen),   .mac_txer_i   (m_txer),
    .mac_tx_take_o(take),    .phy_txc_o  (txc),      .phy_txd_o    (txd),
    .phy_txctl_o  (txctl),   .phy_rxc_i  (rx_clk),   .rx_arst_ni   (rx_rst_n),
    .phy_rxd_i    (rxd),     .phy_rxctl_i(rxctl),    .mac_rxd_o    (o_rxd),
    .mac_rxdv_o   (o_rxdv),  .mac_rxer_o (o_rxer)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] spd, input int half);
    tx_rst_n = 1'b0;
    rx_rst_n = 1'b0;
    speed    = spd;
    rx_half  = half;
    m_txd = 8'h00; m_txen = 1'b0; m_txer = 1'b0;
    rxd = 4'h0; rxctl = 1'b0;
    mdl_pair = 0; mdl_lo = 4'h0; mdl_elo = 1'b0;
    exp_d = 8'h00; exp_dv = 1'b0; exp_er = 1'b0;
    #(4 * half + 20);
    chk("R10", "tx pads", {28'h0, txc, txd, txctl, take}, 32'h0);
    chk("R10", "rx outs", {22'h0, o_rxd, o_rxdv, o_rxer}, 32'h0);
    @(negedge tx_clk);
    tx_rst_n = 1'b1;
    rx_rst_n = 1'b1;
    repeat (3) @(negedge tx_clk);
  endtask

  task automatic new_tx_byte();
    m_txd  = 8'($urandom);
    m_txen = 1'($urandom);
    m_txer = ($urandom % 4) == 0;
  endtask

  task automatic tx_cycles(input int n, input int div, input string rq);
    bit         started = 0;
    bit         stb = 0;
    int         j = 0;
    logic [7:0] cd = 8'h00;
    logic       ce = 1'b0, cer = 1'b0;
    bit         gig = (div == 0);
    int         h = div / 2;
    new_tx_byte();
    repeat (n) begin
      @(posedge tx_clk);
      if (stb) begin
        cd = m_txd; ce = m_txen; cer = m_txer; j = 0; started = 1;
      end else begin
        j++;
      end
      #2;
      if (started) begin
        if (gig) begin
          chk(rq, "R1 txc high half", {31'h0, txc}, 32'd1);
          chk(rq, "R1 low nibble", {28'h0, txd}, {28'h0, cd[3:0]});
          chk(rq, "R2 ctl enable", {31'h0, txctl}, {31'h0, ce});
        end else begin
          chk("R4", "txc level", {31'h0, txc}, {31'h0, ((j % div) < h)});
          chk("R5", "nibble", {28'h0, txd}, {28'h0, (j < div) ? cd[3:0] : cd[7:4]});
          chk("R6", "ctl", {31'h0, txctl}, {31'h0, ((j % div) < h) ? ce : (ce ^ cer)});
        end
      end
      if (stb) new_tx_byte();
      @(negedge tx_clk);
      #2;
      if (started) begin
        if (gig) begin
          chk(rq, "R1 txc low half", {31'h0, txc}, 32'd0);
          chk(rq, "R1 high nibble", {28'h0, txd}, {28'h0, cd[7:4]});
          chk(rq, "R2 ctl encoded error", {31'h0, txctl}, {31'h0, ce ^ cer});
          chk(rq, "R3 take", {31'h0, take}, 32'd1);
        end else begin
          chk("R4", "txc level low half", {31'h0, txc}, {31'h0, ((j % div) < h)});
          chk("R5", "nibble low half", {28'h0, txd}, {28'h0, (j < div) ? cd[3:0] : cd[7:4]});
          chk("R6", "ctl low half", {31'h0, txctl}, {31'h0, ((j % div) < h) ? ce : (ce ^ cer)});
          chk("R5", "take timing", {31'h0, take}, {31'h0, (j == 2 * div - 1)});
        end
      end
      stb = take;
    end
    chk(rq, "byte accepted at all", {31'h0, started}, 32'd1);
  endtask

  task automatic rx_sym(input logic [3:0] lo, input logic [3:0] hi,
                        input logic cr, input logic cf, input string rq);
    @(negedge rx_clk);
    #(rx_half / 2);
    rxd = lo; rxctl = cr;
    @(posedge rx_clk);
    #1;
    chk(rq, "rx byte", {24'h0, o_rxd}, {24'h0, exp_d});
    chk(rq, "rx valid", {31'h0, o_rxdv}, {31'h0, exp_dv});
    chk(rq, "rx error", {31'h0, o_rxer}, {31'h0, exp_er});
    if (speed[1]) begin
      exp_d = {hi, lo}; exp_dv = cr; exp_er = cr ^ cf;
    end else if (!cr) begin
      exp_d = 8'h00; exp_dv = 1'b0; exp_er = cr ^ cf; mdl_pair = 0;
    end else if (!mdl_pair) begin
      mdl_lo = lo; mdl_elo = cr ^ cf; mdl_pair = 1;
      exp_d = 8'h00; exp_dv = 1'b0; exp_er = 1'b0;
    end else begin
      exp_d = {lo, mdl_lo}; exp_dv = 1'b1; exp_er = mdl_elo | (cr ^ cf); mdl_pair = 0;
    end
    #(rx_half / 2 - 1);
    rxd = hi; rxctl = cf;
  endtask

  task automatic rx_idle(input int n, input string rq);
    repeat (n) rx_sym(4'h0, 4'h0, 1'b0, 1'b0, rq);
  endtask

  task automatic rx_burst(input int nibs, input string rq);
    for (int i = 0; i < nibs; i++) begin
      logic [3:0] a = 4'($urandom);
      logic [3:0] b = 4'($urandom);
      logic       e = ($urandom % 5) == 0;
      rx_sym(a, b, 1'b1, ~e, rq);
    end
  endtask

  initial begin
    #500000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // Gigabit transmit and receive
    do_reset(2'b10, 4);
    tx_cycles(40, 0, "R1");
    rx_idle(4, "R10");
    for (int i = 0; i < 24; i++) begin
      rx_sym(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), "R7");
    end
    rx_idle(2, "R7");

    // Speed code 11 must act as gigabit
    do_reset(2'b11, 4);
    tx_cycles(20, 0, "R11");
    rx_idle(3, "R11");
    rx_sym(4'h5, 4'hA, 1'b1, 1'b1, "R11");
    rx_sym(4'h3, 4'hC, 1'b1, 1'b0, "R11");
    rx_idle(2, "R11");

    // 100 Mb/s
    do_reset(2'b01, 20);
    tx_cycles(80, 5, "R4");
    rx_idle(4, "R9");
    rx_burst(8, "R8");
    rx_sym(4'h0, 4'h0, 1'b0, 1'b1, "R9");
    rx_burst(3, "R8");
    rx_idle(1, "R9");
    rx_burst(6, "R8");
    rx_idle(3, "R9");

    // 10 Mb/s
    do_reset(2'b00, 200);
    tx_cycles(420, 50, "R4");
    rx_idle(3, "R9");
    rx_burst(5, "R8");
    rx_sym(4'h0, 4'h7, 1'b0, 1'b1, "R9");
    rx_burst(4, "R8");
    rx_idle(3, "R9");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule